// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block performs the arithmetic and logical step of a 32-bit data-processing instruction. It takes a first operand, a second operand that an external shifter has already prepared, a 4-bit operation selector, a set-flags bit and the carry that leaves the shifter. From these it combinationally produces the result and a write-enable for the destination register.

The block holds four condition flags in registers: negative, zero, carry and overflow. Operations that chain the carry read the registered carry flag as their carry input. The flags take new values at the next clock edge when the operation asks for it. Four compare and test operations only set flags and never write the destination.

Condition evaluation, the shifter, the register file and status restore on exception return are handled by surrounding logic.

Top module: `dp_alu`

## Requirements
- R1: The selector `op` is encoded 0=AND, 1=EOR, 2=SUB, 3=RSB, 4=ADD, 5=ADC, 6=SBC, 7=RSC, 8=TST, 9=TEQ, 10=CMP, 11=CMN, 12=ORR, 13=MOV, 14=BIC, 15=MVN. The logical results are: AND/TST a&b, EOR/TEQ a^b, ORR a|b, BIC a&~b, MOV b, MVN ~b. MOV and MVN ignore `op_a`.
- R2: The arithmetic results, modulo 2^W, are: ADD/CMN a+b, SUB/CMP a-b, RSB b-a.
- R3: `wr_en` is 0 for op 8 to 11 and 1 for every other op. `result` still carries the computed value when `wr_en` is 0.
- R4: The flags are written at the rising clock edge when op is 8 to 11, or when `set_flags` is 1. Otherwise all four flags hold their values.
- R5: On a flag write, N takes bit W-1 of the result, and Z is 1 exactly when the result is all zeros.
- R6: On a flag write by a logical op (0, 1, 8, 9, 12 to 15), C takes `shift_carry` and V keeps its value.
- R7: On a flag write by an arithmetic op, C is the unsigned carry out of the addition. For subtracts this means C is 1 when there is no borrow. V is 1 when the signed result overflows.
- R8: ADC gives a+b+C. SBC gives a-b-(1-C). RSC gives b-a-(1-C). C here is the registered carry flag.
- R9: While `rst_n` is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flag registers |
| op | input | 4 | Operation selector |
| set_flags | input | 1 | Request a flag update |
| op_a | input | W | First operand |
| op_b | input | W | Shifted second operand |
| shift_carry | input | 1 | Carry out of the shifter |
| result | output | W | Operation result |
| wr_en | output | 1 | Destination write-enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The hardest case to reach from the ports combines two conditions. A logical op must leave V untouched after an arithmetic op has set it, and SBC or RSC must run while the carry flag is clear. Both depend on flag state that an earlier operation left behind, not on the current inputs.

The bench instantiates a 4-bit ALU and sweeps every opcode as the innermost loop. It covers all operand pairs, both shifter carries and both set-flags values. Consecutive operations therefore hand each other every reachable flag state. A bench-side model tracks those flags arithmetically.

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op,
  input  logic         set_flags,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         shift_carry,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);
  localparam logic [3:0] OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3;
  localparam logic [3:0] OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7;
  localparam logic [3:0] OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11;
  localparam logic [3:0] OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15;

  logic [W-1:0] lres, x, y;
  logic         ci, arith, upd, ovf;
  logic [W:0]   sum;

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: lres = op_a & op_b;
      OP_EOR, OP_TEQ: lres = op_a ^ op_b;
      OP_ORR:         lres = op_a | op_b;
      OP_MOV:         lres = op_b;
      OP_BIC:         lres = op_a & ~op_b;
      OP_MVN:         lres = ~op_b;
      default:        lres = '0;
    endcase
  end

  always_comb begin
    x = op_a; y = op_b; ci = 1'b0; arith = 1'b1;
    unique case (op)
      OP_ADD, OP_CMN: ;
      OP_ADC:         ci = flag_c;
      OP_SUB, OP_CMP: begin y = ~op_b; ci = 1'b1; end
      OP_SBC:         begin y = ~op_b; ci = flag_c; end
      OP_RSB:         begin x = op_b; y = ~op_a; ci = 1'b1; end
      OP_RSC:         begin x = op_b; y = ~op_a; ci = flag_c; end
      default:        arith = 1'b0;
    endcase
  end

  assign sum    = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign ovf    = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  assign result = arith ? sum[W-1:0] : lres;
  assign wr_en  = (op[3:2] != 2'b10);
  assign upd    = set_flags || !wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_n <= 1'b0; flag_z <= 1'b0; flag_c <= 1'b0; flag_v <= 1'b0;
    end else if (upd) begin
      flag_n <= result[W-1];
      flag_z <= (result == '0);
      flag_c <= arith ? sum[W] : shift_carry;
      if (arith) flag_v <= ovf;
    end
  end

  a_r3_tests_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= OP_TST && op <= OP_CMN) |-> !wr_en);

  a_r4_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !set_flags) |=> $stable({flag_n, flag_z, flag_c, flag_v}));

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags || !wr_en) |=> (flag_z == ($past(result) == '0)) && (flag_n == $past(result[W-1])));

  a_r6_logic_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && (op < OP_SUB || op > OP_CMN || op == OP_TST || op == OP_TEQ))
      |=> (flag_v == $past(flag_v)) && (flag_c == $past(shift_carry)));

  a_r1_mov_ignores_a: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_MOV) |-> (result == op_b));
endmodule

// File: tb/sim_dp_alu.sv
module sim_dp_alu;
  localparam int PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] op = '0;
  logic set_flags = 1'b0, shift_carry = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [W-1:0] result;
  logic wr_en, flag_n, flag_z, flag_c, flag_v;

  int checks = 0, errors = 0;
  bit done = 0;
  bit mn, mz, mc, mv;

  always #(PERIOD/2) clk = ~clk;

  dp_alu #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .op(op), .set_flags(set_flags), .op_a(op_a), .op_b(op_b),
    .shift_carry(shift_carry), .result(result), .wr_en(wr_en),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0d expected=%0d", tag, op, op_a, op_b, act, exp);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ua, ub, sa, sb, r, sr, c, er;
    bit ar, ec, ev, up, ew;
    mn = 0; mz = 0; mc = 0; mv = 0;
    repeat (2) @(posedge clk);
    #1 chk("R9 reset flags", {flag_n, flag_z, flag_c, flag_v}, 0);
    @(negedge clk) rst_n = 1'b1;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int sc = 0; sc < 2; sc++)
          for (int s = 0; s < 2; s++)
            for (int o = 0; o < 16; o++) begin
              @(negedge clk);
              op = o[3:0]; op_a = a[3:0]; op_b = b[3:0];
              set_flags = s[0]; shift_carry = sc[0];
              ua = a; ub = b; sa = (a > 7) ? a - 16 : a; sb = (b > 7) ? b - 16 : b;
              c = mc ? 1 : 0; ar = 1; ec = 0; r = 0; sr = 0;
              case (o)
                0, 8:  begin ar = 0; r = a & b; end
                1, 9:  begin ar = 0; r = a ^ b; end
                12:    begin ar = 0; r = a | b; end
                13:    begin ar = 0; r = b; end
                14:    begin ar = 0; r = a & ~b; end
                15:    begin ar = 0; r = ~b; end
                4, 11: begin r = ua + ub; sr = sa + sb; ec = r > 15; end
                5:     begin r = ua + ub + c; sr = sa + sb + c; ec = r > 15; end
                2, 10: begin r = ua - ub; sr = sa - sb; ec = r >= 0; end
                6:     begin r = ua - ub - (1 - c); sr = sa - sb - (1 - c); ec = r >= 0; end
                3:     begin r = ub - ua; sr = sb - sa; ec = r >= 0; end
                default: begin r = ub - ua - (1 - c); sr = sb - sa - (1 - c); ec = r >= 0; end
              endcase
              er = r & 15;
              ev = ar ? (sr > 7 || sr < -8) : mv;
              if (!ar) ec = sc[0];
              ew = !(o >= 8 && o <= 11);
              up = s[0] || !ew;
              #1;
              if (o == 5 || o == 6 || o == 7) chk("R8 carry-chained result", result, er);
              else if (ar) chk("R2 arithmetic result", result, er);
              else chk("R1 logical result", result, er);
              chk("R3 write enable", wr_en, ew);
              if (up) begin
                mn = er[3]; mz = (er == 0); mc = ec; mv = ev;
              end
              @(posedge clk); #1;
              if (!up) chk("R4 flags held", {flag_n, flag_z, flag_c, flag_v}, {mn, mz, mc, mv});
              else begin
                chk("R5 N/Z flags", {flag_n, flag_z}, {mn, mz});
                if (ar) chk("R7 arithmetic C/V", {flag_c, flag_v}, {mc, mv});
                else chk("R6 logical C/V", {flag_c, flag_v}, {mc, mv});
              end
            end
    @(negedge clk) rst_n = 1'b0;
    #1 chk("R9 reset clears flags", {flag_n, flag_z, flag_c, flag_v}, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule